// File: doc/BRIEF.md
# Interconnect Test Code Generator

This block produces deterministic test codes for a group of board-level nets and sends them out one bit at a time toward a boundary-scan style chain. Each net has a code word. A test vector is the set of bits that all nets carry at one bit position of their codes. The block emits the vectors in order. Within a vector it walks the nets from the first to the last, so one chain load holds exactly one parallel vector.

Three code families are supported, and the family is latched when a sequence starts. Plain binary counting gives each net its own index. Offset counting never hands out the all-zeros word, so an open net stays distinguishable. True/complement repeats the counting vectors inverted, so every net toggles and any two nets differ in at least two positions.

The code word comes from a counter that steps once per shifted net. A vector counter drives a bit-select multiplexer that picks which code bit reaches the serial output. A one-cycle strobe marks each completed vector, so the chain contents can be applied to the nets in parallel. A done flag ends the run.

Top module: `itc_gen`

## Requirements
- R1: While reset is held, and until the first start, `sdata_o`, `update_o` and `done_o` are 0 and `vec_idx_o` is 0.
- R2: With `mode_i` = 0 (counting), net i carries code i, and the bit sent for vector v is bit v of that code (vector 0 is the LSB). There are ceil(log2(NETS)) vectors.
- R3: With `mode_i` = 1 (offset counting), net i carries code i+1, so code 0 is never used. The bit for vector v is bit v of that code, and there are ceil(log2(NETS+2)) vectors.
- R4: With `mode_i` = 2 (true/complement), there are 2*ceil(log2(NETS)) vectors. Vector v below L = ceil(log2(NETS)) sends bit v of code i. Vector v at or above L sends the inverse of bit v-L.
- R5: Order is vector-major. A cycle with `shift_en_i` high shifts one bit. Within a vector, nets go 0 to NETS-1, and then the vector advances. `vec_idx_o` shows the vector that holds the bit on `sdata_o`.
- R6: `update_o` is high for exactly the one cycle that follows the shift of the last net of each vector. It is low at every other time.
- R7: `done_o` rises in the cycle after the last bit of the last vector is shifted, together with that vector's update strobe. After that, further shifts have no effect: `sdata_o` = 0, `vec_idx_o` keeps the last vector, and `done_o` stays 1.
- R8: While `shift_en_i` is low, the net position, the vector index and the serial bit do not change.
- R9: A `start_i` pulse restarts at vector 0, net 0 at any point and latches `mode_i`. Changes of `mode_i` at any other time are ignored.
- R10: `mode_i` = 3 behaves exactly like counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Code family: 0 counting, 1 offset counting, 2 true/complement, 3 counting |
| start_i | input | 1 | Restart the sequence and latch the mode |
| shift_en_i | input | 1 | Shift one bit this cycle |
| sdata_o | output | 1 | Serial code bit for the current net and vector |
| vec_idx_o | output | VIDX_W | Index of the current vector |
| update_o | output | 1 | One-cycle strobe after each completed vector |
| done_o | output | 1 | Whole sequence shifted |

## Verification
The hardest cases to reach are the complement half of the true/complement sequence and the cycle where the last net of the last vector is shifted. The first depends on the vector index passing L, and the second is the one point where the update strobe, the done flag and the stop of the run must line up. The bench reaches both by driving complete sequences for every mode from a table. Some table entries insert an idle cycle after every shift, to test freezing. A restart in the middle of a sequence, with `mode_i` changed beforehand, shows that the mode is latched only at start.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [1:0] {
    ITC_COUNT    = 2'd0,
    ITC_OFFSET   = 2'd1,
    ITC_TRUECOMP = 2'd2
  } itc_mode_e;

  // Encoding 3 is folded onto plain counting
  function automatic itc_mode_e itc_norm(input logic [1:0] m);
    itc_mode_e r;
    case (m)
      2'd1:    r = ITC_OFFSET;
      2'd2:    r = ITC_TRUECOMP;
      default: r = ITC_COUNT;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/itc_rst_sync.sv
module itc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/itc_seq_ctrl.sv
module itc_seq_ctrl
  import itc_pkg::*;
#(
  parameter int NETS   = 7,
  parameter int CODE_W = 4,
  parameter int NET_W  = $clog2(NETS),
  parameter int VIDX_W = $clog2(2 * $clog2(NETS) + 1),
  parameter int SEL_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              shift_en_i,
  input  itc_mode_e         mode_i,
  output logic              run_o,
  output logic              shift_o,
  output logic              wrap_o,
  output logic [NET_W-1:0]  net_o,
  output logic [VIDX_W-1:0] vec_o,
  output itc_mode_e         mode_o,
  output logic [SEL_W-1:0]  bit_sel_o,
  output logic              invert_o,
  output logic              update_o,
  output logic              done_o
);

  localparam int LEN_C = $clog2(NETS);
  localparam int LEN_M = $clog2(NETS + 2);
  localparam int LEN_T = 2 * LEN_C;

  logic [NET_W-1:0]  net_q, net_d;
  logic [VIDX_W-1:0] vec_q, vec_d;
  itc_mode_e         mode_q, mode_d;
  logic              run_q, run_d;
  logic              done_q, done_d;
  logic              upd_q, upd_d;

  logic              shift;
  logic              last_net;
  logic              last_vec;
  logic [VIDX_W-1:0] vec_max;
  logic [VIDX_W-1:0] rel_pos;

  always_comb begin
    case (mode_q)
      ITC_OFFSET:   vec_max = VIDX_W'(LEN_M - 1);
      ITC_TRUECOMP: vec_max = VIDX_W'(LEN_T - 1);
      default:      vec_max = VIDX_W'(LEN_C - 1);
    endcase
  end

  assign shift    = run_q & shift_en_i;
  assign last_net = (net_q == NET_W'(NETS - 1));
  assign last_vec = (vec_q == vec_max);

  // next state
  always_comb begin
    net_d  = net_q;
    vec_d  = vec_q;
    mode_d = mode_q;
    run_d  = run_q;
    done_d = done_q;
    upd_d  = 1'b0;
    if (start_i) begin
      net_d  = '0;
      vec_d  = '0;
      mode_d = mode_i;
      run_d  = 1'b1;
      done_d = 1'b0;
    end else if (shift) begin
      if (last_net) begin
        net_d = '0;
        upd_d = 1'b1;
        if (last_vec) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          vec_d = vec_q + 1'b1;
        end
      end else begin
        net_d = net_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      net_q  <= '0;
      vec_q  <= '0;
      mode_q <= ITC_COUNT;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      net_q  <= net_d;
      vec_q  <= vec_d;
      mode_q <= mode_d;
      run_q  <= run_d;
      done_q <= done_d;
      upd_q  <= upd_d;
    end
  end

  // bit position within the code word, folded for the complement half
  always_comb begin
    rel_pos  = vec_q;
    invert_o = 1'b0;
    if (mode_q == ITC_TRUECOMP && vec_q >= VIDX_W'(LEN_C)) begin
      rel_pos  = vec_q - VIDX_W'(LEN_C);
      invert_o = 1'b1;
    end
  end

  assign bit_sel_o = SEL_W'(rel_pos);
  assign run_o     = run_q;
  assign shift_o   = shift;
  assign wrap_o    = last_net;
  assign net_o     = net_q;
  assign vec_o     = vec_q;
  assign mode_o    = mode_q;
  assign update_o  = upd_q;
  assign done_o    = done_q;

  a_r6_update_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

  a_r7_done_with_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> upd_q);

  a_r7_done_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q);

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !shift_en_i) |=> ($stable(net_q) && $stable(vec_q)));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (run_q && vec_q == '0 && net_q == '0 && !done_q));

  a_r5_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (vec_q <= vec_max));

endmodule

// File: rtl/itc_code_gen.sv
module itc_code_gen #(
  parameter int CODE_W = 4,
  parameter int SEL_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              load_base_i,
  input  logic              step_i,
  input  logic              wrap_i,
  input  logic              run_base_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  input  logic              invert_i,
  input  logic              active_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sdata_o
);

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] hit;
  logic              sel_bit;

  always_comb begin
    code_d = code_q;
    if (load_i)      code_d = CODE_W'(load_base_i);
    else if (step_i) code_d = wrap_i ? CODE_W'(run_base_i) : code_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  // bit-select multiplexer, one match term per code bit
  for (genvar g = 0; g < CODE_W; g++) begin : g_sel
    assign hit[g] = (bit_sel_i == SEL_W'(g)) & code_q[g];
  end

  assign sel_bit = |hit;
  assign sdata_o = active_i & (sel_bit ^ invert_i);
  assign code_o  = code_q;

  a_r3_no_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && run_base_i) |-> (code_q != '0));

endmodule

// File: rtl/itc_gen.sv
module itc_gen
  import itc_pkg::*;
#(
  parameter int NETS   = 7,
  parameter int CODE_W = 4,
  parameter int NET_W  = $clog2(NETS),
  parameter int VIDX_W = $clog2(2 * $clog2(NETS) + 1),
  parameter int SEL_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic              shift_en_i,
  output logic              sdata_o,
  output logic [VIDX_W-1:0] vec_idx_o,
  output logic              update_o,
  output logic              done_o
);

  logic              rst_sync_n;
  itc_mode_e         mode_in;
  itc_mode_e         mode_q;
  logic              run;
  logic              shift;
  logic              wrap;
  logic [NET_W-1:0]  net;
  logic [SEL_W-1:0]  bit_sel;
  logic              invert;
  logic [CODE_W-1:0] code;

  assign mode_in = itc_norm(mode_i);

  itc_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  itc_seq_ctrl #(
    .NETS   (NETS),
    .CODE_W (CODE_W),
    .NET_W  (NET_W),
    .VIDX_W (VIDX_W),
    .SEL_W  (SEL_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .shift_en_i (shift_en_i),
    .mode_i     (mode_in),
    .run_o      (run),
    .shift_o    (shift),
    .wrap_o     (wrap),
    .net_o      (net),
    .vec_o      (vec_idx_o),
    .mode_o     (mode_q),
    .bit_sel_o  (bit_sel),
    .invert_o   (invert),
    .update_o   (update_o),
    .done_o     (done_o)
  );

  itc_code_gen #(
    .CODE_W (CODE_W),
    .SEL_W  (SEL_W)
  ) code_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (start_i),
    .load_base_i (mode_in == ITC_OFFSET),
    .step_i      (shift),
    .wrap_i      (wrap),
    .run_base_i  (mode_q == ITC_OFFSET),
    .bit_sel_i   (bit_sel),
    .invert_i    (invert),
    .active_i    (run),
    .code_o      (code),
    .sdata_o     (sdata_o)
  );

  // code counter and net counter stay in step (R2, R3)
  a_r2_code_tracks_net: assert property (@(posedge clk) disable iff (!rst_sync_n)
    run |-> (code == CODE_W'(net) + CODE_W'(mode_q == ITC_OFFSET)));

  a_r7_idle_output_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |-> !sdata_o);

endmodule

// File: tb/itc_gen_tb_top.sv
module itc_gen_tb_top;

  localparam int NETS   = 7;
  localparam int CODE_W = 4;
  localparam int VIDX_W = $clog2(2 * $clog2(NETS) + 1);
  localparam int LEN_C  = $clog2(NETS);

  // table entry: mode[6:5], vector count[4:1], idle-gap flag[0]
  localparam int NTAB = 5;
  localparam logic [6:0] TAB [NTAB] = '{
    {2'd0, 4'd3, 1'b0},
    {2'd1, 4'd4, 1'b0},
    {2'd2, 4'd6, 1'b0},
    {2'd3, 4'd3, 1'b1},
    {2'd2, 4'd6, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode_i;
  logic              start_i;
  logic              shift_en_i;
  logic              sdata_o;
  logic [VIDX_W-1:0] vec_idx_o;
  logic              update_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  itc_gen #(.NETS(NETS), .CODE_W(CODE_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .start_i    (start_i),
    .shift_en_i (shift_en_i),
    .sdata_o    (sdata_o),
    .vec_idx_o  (vec_idx_o),
    .update_o   (update_o),
    .done_o     (done_o)
  );

  function automatic logic exp_bit(input int m, input int v, input int n);
    int code;
    code = (m == 1) ? n + 1 : n;
    if (m == 2 && v >= LEN_C) return ~code[v - LEN_C];
    return code[v];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] m);
    mode_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic shift_one();
    shift_en_i = 1'b1;
    @(negedge clk);
    shift_en_i = 1'b0;
  endtask

  task automatic run_seq(input logic [1:0] m, input int nvec, input bit gap);
    string tag;
    tag = (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : (m == 2'd3) ? "R10" : "R2";
    pulse_start(m);
    chk("R9 restart vector", int'(vec_idx_o), 0);
    chk("R9 restart done", int'(done_o), 0);
    for (int v = 0; v < nvec; v++) begin
      for (int n = 0; n < NETS; n++) begin
        chk({tag, " serial bit"}, int'(sdata_o), int'(exp_bit(int'(m), v, n)));
        chk("R5 vector index", int'(vec_idx_o), v);
        shift_one();
        chk("R6 update strobe", int'(update_o), (n == NETS - 1) ? 1 : 0);
        chk("R7 done timing", int'(done_o), (v == nvec - 1 && n == NETS - 1) ? 1 : 0);
        if (gap && !(v == nvec - 1 && n == NETS - 1)) begin
          @(negedge clk);
          chk("R6 update one cycle", int'(update_o), 0);
          chk("R8 frozen vector", int'(vec_idx_o), (n == NETS - 1) ? v + 1 : v);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    mode_i     = 2'd0;
    start_i    = 1'b0;
    shift_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sdata", int'(sdata_o), 0);
    chk("R1 reset update", int'(update_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset vector", int'(vec_idx_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    shift_one();
    chk("R1 no start sdata", int'(sdata_o), 0);
    chk("R1 no start vector", int'(vec_idx_o), 0);
    chk("R1 no start update", int'(update_o), 0);

    for (int t = 0; t < NTAB; t++) begin
      run_seq(TAB[t][6:5], int'(TAB[t][4:1]), TAB[t][0]);
      chk("R7 done held", int'(done_o), 1);
      shift_one();
      chk("R7 sdata after done", int'(sdata_o), 0);
      chk("R7 vector kept", int'(vec_idx_o), int'(TAB[t][4:1]) - 1);
      chk("R7 no extra update", int'(update_o), 0);
      chk("R7 done stays", int'(done_o), 1);
    end

    // mid-sequence mode change is ignored, start restarts (R9)
    pulse_start(2'd2);
    for (int k = 0; k < 9; k++) shift_one();
    mode_i = 2'd1;
    @(negedge clk);
    chk("R9 mode ignored bit", int'(sdata_o), int'(exp_bit(2, 1, 2)));
    chk("R9 mode ignored vector", int'(vec_idx_o), 1);
    for (int k = 0; k < 12; k++) shift_one();
    chk("R9 still true/comp vector", int'(vec_idx_o), 3);
    chk("R9 still true/comp bit", int'(sdata_o), int'(exp_bit(2, 3, 0)));
    pulse_start(2'd1);
    chk("R9 restart vector zero", int'(vec_idx_o), 0);
    chk("R9 restart first bit", int'(sdata_o), int'(exp_bit(1, 0, 0)));
    chk("R9 restart done low", int'(done_o), 0);
    shift_one();
    chk("R9 restart second bit", int'(sdata_o), int'(exp_bit(1, 0, 1)));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule